// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits between a request source and a serial-flash command framer. A request names an operation (read, page program or erase), a start byte address and a byte count. The sequencer validates the request against a flash geometry fixed by parameters: bytes per page, pages per sector and number of sectors. It then drives the framer one command at a time and returns a single response that holds a status code and a granted length.

Program and erase run as a sequence. A write-enable command comes first, then the operation itself, then status reads that repeat until the busy flag clears, with a fixed pause between reads. Erase picks the cheapest opcode for the size asked: whole chip, 4 KiB, 32 KiB, or one sector erase per sector. Reads are trimmed so that one command never crosses a page boundary or the end of the device, and the caller gets back the length actually read. The data payload is moved by the framer and is never buffered here.

Top module: `flash_op_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `cmd_valid` and `rsp_valid` are 0. A request is taken only while `req_ready` is 1. Every request yields exactly one `rsp_valid` pulse lasting one cycle. While `cmd_valid` is 1 and `cmd_done` is 0, the command fields hold steady. Operation codes on `req_op`: 0 read, 1 program, 2 erase, 3 rejected as overflow.
- R2: A program or erase that passes its checks first issues write-enable (opcode 0x06, `cmd_addr_en`=0, `cmd_len`=0, `cmd_read`=0), and only then the operation.
- R3: After the last program or erase command, status reads are issued (opcode 0x05, `cmd_addr_en`=0, `cmd_len`=1, `cmd_read`=1) until the returned byte has bit 0 clear. Between a status read that reports busy and the next one, `cmd_valid` stays low for at least POLL_GAP cycles. The response follows the idle status read.
- R4: A program whose size exceeds one page, or whose first and last bytes sit in different pages, is answered with status 1 (overflow) and no command.
- R5: A program or erase whose address plus size exceeds the device capacity is answered with overflow and no command.
- R6: An erase whose start address is not a multiple of the sector size is answered with status 2 (misaligned) and no command. This check comes before the capacity check.
- R7: Erase opcode choice: a size equal to the capacity issues 0xC7 with `cmd_addr_en`=0. Otherwise, 4096 bytes issues 0x20 and 32768 bytes issues 0x52, each carrying the address. Any other nonzero multiple of the sector size issues 0xD8 once per sector, with the address rising by one sector each time. Any other size is overflow. Erase responses report length 0.
- R8: A read issues 0x03 with the address and `cmd_read`=1. `cmd_len` is the request size, limited to the bytes left in the start page and to the bytes left before the end of the device. That same value is returned in `rsp_len` with status 0.
- R9: A read whose start address is above the capacity gets overflow. A read whose granted length is zero gets status 0 and length 0, with no command.
- R10: A program or erase of size zero (erase with an aligned address) completes with status 0, length 0 and no command.
- R11: A valid program issues 0x02 with the address, `cmd_len` equal to the size and `cmd_read`=0, and returns the size in `rsp_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_op | input | 2 | 0 read, 1 program, 2 erase |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | ADDR_W | Byte count |
| cmd_valid | output | 1 | Command to the framer, held until done |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr_en | output | 1 | Address phase present |
| cmd_addr | output | ADDR_W | Address sent with the command |
| cmd_len | output | ADDR_W | Data bytes after opcode and address |
| cmd_read | output | 1 | Data phase flows from the flash |
| cmd_done | input | 1 | Framer finished the current command |
| cmd_rdata | input | 8 | Status byte, valid with cmd_done |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 0 OK, 1 overflow, 2 misaligned |
| rsp_len | output | ADDR_W | Granted length |

## Verification
Two functions share an edge here. The framer's completion of one command lands on the same clock edge as the launch of the next: write-enable into the operation, one sector erase into the following one, and the operation into the first status read. The bench provokes this with multi-sector erases and programs whose flash model answers busy a chosen number of times. It judges the outcome from the full command log of each request, and from the count of idle cycles seen between successive status reads, all compared with a list the bench builds from the requirements.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_NONE = 2'd3} op_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_OVF = 2'd1, ST_MISAL = 2'd2, ST_RSVD = 2'd3} stat_e;
  typedef enum logic [1:0] {ER_CHIP, ER_4K, ER_32K, ER_SECT} erase_e;
  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_WREN, S_OP, S_POLL, S_GAP} state_e;
endpackage

// File: rtl/flash_req_check.sv
module flash_req_check
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES       = 256,
  parameter int PAGES_PER_SECTOR = 16,
  parameter int SECTOR_COUNT     = 64,
  parameter int ADDR_W           = 24,
  parameter bit HAS_4K           = 1'b1,
  parameter bit HAS_32K          = 1'b1,
  parameter int CNT_W            = 7
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] size,
  output stat_e             status,
  output logic              skip,
  output logic [ADDR_W-1:0] grant,
  output erase_e            ekind,
  output logic [CNT_W-1:0]  ecount
);
  localparam int XW         = ADDR_W + 1;
  localparam int PAGE_LG    = $clog2(PAGE_BYTES);
  localparam int SECT_BYTES = PAGE_BYTES * PAGES_PER_SECTOR;
  localparam int SECT_LG    = $clog2(SECT_BYTES);
  localparam logic [XW-1:0] TOTAL  = XW'(SECT_BYTES * SECTOR_COUNT);
  localparam logic [XW-1:0] PAGE_X = XW'(PAGE_BYTES);
  localparam logic [XW-1:0] SZ_4K  = XW'(4096);
  localparam logic [XW-1:0] SZ_32K = XW'(32768);

  logic [XW-1:0] a_x, s_x, end_x, room_pg, room_chip, rlen, rlen_cap;

  always_comb begin
    a_x       = {1'b0, addr};
    s_x       = {1'b0, size};
    end_x     = a_x + s_x;
    room_chip = (a_x > TOTAL) ? '0 : TOTAL - a_x;
    room_pg   = PAGE_X - XW'(addr[PAGE_LG-1:0]);
    // room_pg never exceeds a page, so this also clamps to one page
    rlen      = (s_x > room_pg) ? room_pg : s_x;
    rlen_cap  = (rlen > room_chip) ? room_chip : rlen;

    status = ST_OK;
    skip   = 1'b0;
    grant  = '0;
    ekind  = ER_SECT;
    ecount = CNT_W'(1);
    unique case (op)
      OP_READ: begin
        if (a_x > TOTAL) begin
          status = ST_OVF;
          skip   = 1'b1;
        end else begin
          grant = rlen_cap[ADDR_W-1:0];
          skip  = (rlen_cap == '0);
        end
      end
      OP_PROG: begin
        if (s_x == '0) skip = 1'b1;
        else if (s_x > PAGE_X || s_x > room_pg || end_x > TOTAL) begin
          status = ST_OVF;
          skip   = 1'b1;
        end else grant = size;
      end
      OP_ERASE: begin
        if (addr[SECT_LG-1:0] != '0) begin
          status = ST_MISAL;
          skip   = 1'b1;
        end else if (end_x > TOTAL) begin
          status = ST_OVF;
          skip   = 1'b1;
        end else if (s_x == '0) skip = 1'b1;
        else if (s_x == TOTAL) ekind = ER_CHIP;
        else if (HAS_4K && s_x == SZ_4K) ekind = ER_4K;
        else if (HAS_32K && s_x == SZ_32K) ekind = ER_32K;
        else if (size[SECT_LG-1:0] != '0) begin
          status = ST_OVF;
          skip   = 1'b1;
        end else ecount = CNT_W'(s_x >> SECT_LG);
      end
      default: begin
        status = ST_OVF;
        skip   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/flash_gap_timer.sv
module flash_gap_timer #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(GAP + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= CW'(GAP);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == CW'(1));

  AST_GAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(GAP)); // R3
  AST_GAP_COUNTS: assert property (@(posedge clk) disable iff (rst)
    (cnt > CW'(1) && !start) |=> (cnt == $past(cnt) - CW'(1))); // R3
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES       = 256,
  parameter int PAGES_PER_SECTOR = 16,
  parameter int SECTOR_COUNT     = 64,
  parameter int ADDR_W           = 24,
  parameter bit HAS_4K           = 1'b1,
  parameter bit HAS_32K          = 1'b1,
  parameter int POLL_GAP         = 4,
  parameter logic [7:0] BUSY_MASK      = 8'h01,
  parameter logic [7:0] OPC_WREN       = 8'h06,
  parameter logic [7:0] OPC_RDSR       = 8'h05,
  parameter logic [7:0] OPC_READ       = 8'h03,
  parameter logic [7:0] OPC_PROG       = 8'h02,
  parameter logic [7:0] OPC_ERASE_CHIP = 8'hC7,
  parameter logic [7:0] OPC_ERASE_4K   = 8'h20,
  parameter logic [7:0] OPC_ERASE_32K  = 8'h52,
  parameter logic [7:0] OPC_ERASE_SECT = 8'hD8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_size,
  output logic              cmd_valid,
  output logic [7:0]        cmd_opcode,
  output logic              cmd_addr_en,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_len,
  output logic              cmd_read,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_rdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [ADDR_W-1:0] rsp_len
);
  localparam int SECT_BYTES = PAGE_BYTES * PAGES_PER_SECTOR;
  localparam int PAGE_LG    = $clog2(PAGE_BYTES);
  localparam int CNT_W      = $clog2(SECTOR_COUNT + 1);
  localparam int XW         = ADDR_W + 1;

  typedef struct packed {
    logic [7:0]        opc;
    logic              aen;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] len;
    logic              rd;
  } cmd_t;

  function automatic cmd_t mk(input logic [7:0] o, input logic ae,
                              input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] l,
                              input logic rd);
    cmd_t c;
    c.opc = o; c.aen = ae; c.addr = a; c.len = l; c.rd = rd;
    return c;
  endfunction

  state_e            st;
  op_e               r_op;
  logic [ADDR_W-1:0] r_addr, r_size, cur_addr;
  logic [CNT_W-1:0]  left;
  logic              wren_ok;
  cmd_t              cmd_q;
  stat_e             chk_st;
  logic              chk_skip;
  logic [ADDR_W-1:0] chk_grant;
  erase_e            chk_kind;
  logic [CNT_W-1:0]  chk_cnt;
  logic [7:0]        er_opc;
  logic              busy, gap_start, gap_done;

  flash_req_check #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_SECTOR(PAGES_PER_SECTOR),
    .SECTOR_COUNT(SECTOR_COUNT), .ADDR_W(ADDR_W),
    .HAS_4K(HAS_4K), .HAS_32K(HAS_32K), .CNT_W(CNT_W)
  ) u_check (
    .op(r_op), .addr(r_addr), .size(r_size),
    .status(chk_st), .skip(chk_skip), .grant(chk_grant),
    .ekind(chk_kind), .ecount(chk_cnt)
  );

  assign busy      = |(cmd_rdata & BUSY_MASK);
  assign gap_start = (st == S_POLL) && cmd_done && busy;

  flash_gap_timer #(.GAP(POLL_GAP)) u_gap (
    .clk(clk), .rst(rst), .start(gap_start), .expired(gap_done)
  );

  always_comb begin
    unique case (chk_kind)
      ER_CHIP: er_opc = OPC_ERASE_CHIP;
      ER_4K:   er_opc = OPC_ERASE_4K;
      ER_32K:  er_opc = OPC_ERASE_32K;
      default: er_opc = OPC_ERASE_SECT;
    endcase
  end

  assign req_ready   = (st == S_IDLE);
  assign cmd_opcode  = cmd_q.opc;
  assign cmd_addr_en = cmd_q.aen;
  assign cmd_addr    = cmd_q.addr;
  assign cmd_len     = cmd_q.len;
  assign cmd_read    = cmd_q.rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      r_op       <= OP_READ;
      r_addr     <= '0;
      r_size     <= '0;
      cur_addr   <= '0;
      left       <= '0;
      wren_ok    <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_len    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          r_op    <= op_e'(req_op);
          r_addr  <= req_addr;
          r_size  <= req_size;
          wren_ok <= 1'b0;
          st      <= S_DECIDE;
        end
        S_DECIDE: begin
          cur_addr <= r_addr;
          left     <= chk_cnt;
          if (chk_skip) begin
            rsp_valid  <= 1'b1;
            rsp_status <= chk_st;
            rsp_len    <= (chk_st == ST_OK) ? chk_grant : '0;
            st         <= S_IDLE;
          end else if (r_op == OP_READ) begin
            cmd_valid <= 1'b1;
            cmd_q     <= mk(OPC_READ, 1'b1, r_addr, chk_grant, 1'b1);
            st        <= S_OP;
          end else begin
            cmd_valid <= 1'b1;
            cmd_q     <= mk(OPC_WREN, 1'b0, '0, '0, 1'b0);
            st        <= S_WREN;
          end
        end
        S_WREN: if (cmd_done) begin
          wren_ok <= 1'b1;
          if (r_op == OP_PROG) cmd_q <= mk(OPC_PROG, 1'b1, cur_addr, chk_grant, 1'b0);
          else cmd_q <= mk(er_opc, chk_kind != ER_CHIP,
                           (chk_kind == ER_CHIP) ? '0 : cur_addr, '0, 1'b0);
          st <= S_OP;
        end
        S_OP: if (cmd_done) begin
          if (r_op == OP_READ) begin
            cmd_valid  <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_len    <= chk_grant;
            st         <= S_IDLE;
          end else if (r_op == OP_ERASE && left > CNT_W'(1)) begin
            left     <= left - CNT_W'(1);
            cur_addr <= cur_addr + ADDR_W'(SECT_BYTES);
            cmd_q    <= mk(er_opc, 1'b1, cur_addr + ADDR_W'(SECT_BYTES), '0, 1'b0);
          end else begin
            cmd_q <= mk(OPC_RDSR, 1'b0, '0, ADDR_W'(1), 1'b1);
            st    <= S_POLL;
          end
        end
        S_POLL: if (cmd_done) begin
          cmd_valid <= 1'b0;
          if (busy) st <= S_GAP;
          else begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_len    <= chk_grant;
            st         <= S_IDLE;
          end
        end
        S_GAP: if (gap_done) begin
          cmd_valid <= 1'b1;
          cmd_q     <= mk(OPC_RDSR, 1'b0, '0, ADDR_W'(1), 1'b1);
          st        <= S_POLL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr)
                                  && $stable(cmd_len) && $stable(cmd_read))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !cmd_valid); // R1
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R1
  AST_WREN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_opcode == OPC_PROG || cmd_opcode == OPC_ERASE_SECT ||
     cmd_opcode == OPC_ERASE_4K || cmd_opcode == OPC_ERASE_32K ||
     cmd_opcode == OPC_ERASE_CHIP)) |-> wren_ok); // R2
  AST_POLL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(st == S_POLL)) |-> $past(!busy)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_opcode == OPC_PROG) |->
      (XW'(cmd_addr[PAGE_LG-1:0]) + XW'(cmd_len) <= XW'(PAGE_BYTES))); // R4
  AST_READ_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_opcode == OPC_READ) |->
      (XW'(cmd_addr[PAGE_LG-1:0]) + XW'(cmd_len) <= XW'(PAGE_BYTES))); // R8
endmodule

// File: tb/test_flash_op_seq.sv
`timescale 1ns/1ps
module test_flash_op_seq;
  localparam longint PAGE = 256, SECT = 4096, TOTAL = 262144;
  localparam int GAP = 4, LOGN = 160;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [23:0] req_addr = '0, req_size = '0;
  logic cmd_valid, cmd_addr_en, cmd_read, cmd_done, rsp_valid;
  logic [7:0] cmd_opcode, cmd_rdata;
  logic [23:0] cmd_addr, cmd_len, rsp_len;
  logic [1:0] rsp_status;

  flash_op_seq i_flash_op_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_addr_en(cmd_addr_en),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_read(cmd_read),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_len(rsp_len)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] lg_opc[LOGN]; logic lg_aen[LOGN], lg_rd[LOGN];
  longint lg_addr[LOGN], lg_len[LOGN]; int lg_gap[LOGN];
  int log_n = 0, busy_left = 0, idle_cnt = 0;

  logic [7:0] ex_opc[LOGN]; logic ex_aen[LOGN], ex_rd[LOGN];
  longint ex_addr[LOGN], ex_len[LOGN];
  int ex_n, ex_st; longint ex_len_rsp; string ex_tag;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // flash/framer model: answers each command after two cycles
  initial begin : framer
    cmd_done = 1'b0; cmd_rdata = 8'h00;
    forever begin
      @(negedge clk);
      while (cmd_valid) begin
        if (log_n < LOGN) begin
          lg_opc[log_n] = cmd_opcode; lg_aen[log_n] = cmd_addr_en; lg_rd[log_n] = cmd_read;
          lg_addr[log_n] = longint'(cmd_addr); lg_len[log_n] = longint'(cmd_len);
          lg_gap[log_n] = idle_cnt;
        end
        log_n++; idle_cnt = 0;
        repeat (2) @(negedge clk);
        cmd_done = 1'b1;
        if (cmd_opcode == 8'h05 && busy_left > 0) begin cmd_rdata = 8'h03; busy_left--; end
        else cmd_rdata = 8'h02;
        @(negedge clk);
        cmd_done = 1'b0;
      end
      idle_cnt++;
    end
  end

  task automatic push(input logic [7:0] o, input logic ae, input longint a,
                      input longint l, input logic rd);
    ex_opc[ex_n] = o; ex_aen[ex_n] = ae; ex_addr[ex_n] = a; ex_len[ex_n] = l; ex_rd[ex_n] = rd;
    ex_n++;
  endtask

  task automatic add_polls(input int busy);
    for (int i = 0; i <= busy; i++) push(8'h05, 1'b0, 0, 1, 1'b1);
  endtask

  task automatic build(input int op, input longint a, input longint s, input int busy);
    longint g;
    ex_n = 0; ex_st = 0; ex_len_rsp = 0;
    if (op == 0) begin
      ex_tag = "R8";
      if (a > TOTAL) begin ex_st = 1; ex_tag = "R9"; end
      else begin
        g = (s > PAGE) ? PAGE : s;
        if (a + g > TOTAL) g = TOTAL - a;
        if (g > 0 && (a / PAGE) != ((a + g - 1) / PAGE)) g = PAGE - (a % PAGE);
        ex_len_rsp = g;
        if (g > 0) push(8'h03, 1'b1, a, g, 1'b1); else ex_tag = "R9";
      end
    end else if (op == 1) begin
      ex_tag = "R11";
      if (s == 0) ex_tag = "R10";
      else if (s > PAGE || (a / PAGE) != ((a + s - 1) / PAGE)) begin ex_st = 1; ex_tag = "R4"; end
      else if (a + s > TOTAL) begin ex_st = 1; ex_tag = "R5"; end
      else begin
        ex_len_rsp = s;
        push(8'h06, 1'b0, 0, 0, 1'b0); push(8'h02, 1'b1, a, s, 1'b0); add_polls(busy);
      end
    end else begin
      ex_tag = "R7";
      if (a % SECT != 0) begin ex_st = 2; ex_tag = "R6"; end
      else if (a + s > TOTAL) begin ex_st = 1; ex_tag = "R5"; end
      else if (s == 0) ex_tag = "R10";
      else if (s != TOTAL && s != 4096 && s != 32768 && s % SECT != 0) ex_st = 1;
      else begin
        push(8'h06, 1'b0, 0, 0, 1'b0);
        if (s == TOTAL) push(8'hC7, 1'b0, 0, 0, 1'b0);
        else if (s == 4096) push(8'h20, 1'b1, a, 0, 1'b0);
        else if (s == 32768) push(8'h52, 1'b1, a, 0, 1'b0);
        else for (longint k = 0; k < s / SECT; k++) push(8'hD8, 1'b1, a + k * SECT, 0, 1'b0);
        add_polls(busy);
      end
    end
  endtask

  task automatic run_req(input int op, input longint a, input longint s, input int busy);
    int t; int st_got; longint len_got; bit ok; int bad;
    build(op, a, s, busy);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    log_n = 0; busy_left = busy;
    req_valid = 1'b1; req_op = 2'(op); req_addr = a[23:0]; req_size = s[23:0];
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 20000) begin @(negedge clk); t++; end
    check(rsp_valid, "R1", "response arrived", rsp_valid, 1);
    st_got = int'(rsp_status); len_got = longint'(rsp_len);
    @(negedge clk);
    check(!rsp_valid, "R1", "response pulse width", rsp_valid, 0);
    check(st_got == ex_st, ex_tag, "status", st_got, ex_st);
    check(len_got == ex_len_rsp, ex_tag, "rsp_len", len_got, ex_len_rsp);
    check(log_n == ex_n, ex_tag, "command count", log_n, ex_n);
    ok = 1; bad = 0;
    for (int i = 0; i < ex_n && i < log_n && i < LOGN; i++)
      if (ok && !(lg_opc[i] == ex_opc[i] && lg_aen[i] == ex_aen[i] && lg_rd[i] == ex_rd[i] &&
                  lg_len[i] == ex_len[i] && (!ex_aen[i] || lg_addr[i] == ex_addr[i]))) begin
        ok = 0; bad = i;
      end
    if (!ok) check(0, ex_tag, $sformatf("cmd %0d opcode/addr", bad),
                   (longint'(lg_opc[bad]) << 32) | lg_addr[bad],
                   (longint'(ex_opc[bad]) << 32) | ex_addr[bad]);
    else check(1, ex_tag, "command list", 0, 0);
    if (ex_n > 0 && op != 0) check(lg_opc[0] == 8'h06, "R2", "first command", lg_opc[0], 8'h06);
    for (int i = 1; i < log_n && i < LOGN; i++)
      if (lg_opc[i] == 8'h05 && lg_opc[i-1] == 8'h05)
        check(lg_gap[i] >= GAP, "R3", "idle cycles between status reads", lg_gap[i], GAP);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    int op, md; longint a, s;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    check(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
    check(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
    rst = 1'b0;
    // directed corner cases
    run_req(0, 'h10, 100, 0);            // R8 plain read
    run_req(0, 'hF0, 'h40, 0);           // R8 split at page end
    run_req(0, 'h100, 1000, 0);          // R8 clamp to one page
    run_req(0, TOTAL - 8, 256, 0);       // R8 clamp to chip end
    run_req(0, TOTAL, 4, 0);             // R9 zero grant
    run_req(0, TOTAL + 1, 4, 0);         // R9 beyond capacity
    run_req(1, 'h200, 256, 2);           // R11 R2 R3
    run_req(1, 'h2F0, 32, 0);            // R4 crosses page
    run_req(1, 'h300, 257, 0);           // R4 larger than page
    run_req(1, 'h400, 0, 0);             // R10
    run_req(1, TOTAL, 4, 0);             // R5
    run_req(2, 'h1000, 4096, 1);         // R7 4 KiB
    run_req(2, 'h8000, 32768, 0);        // R7 32 KiB
    run_req(2, 0, TOTAL, 3);             // R7 chip
    run_req(2, 'h2000, 3 * SECT, 2);     // R7 per sector, back to back
    run_req(2, 'h1004, 4096, 0);         // R6
    run_req(2, TOTAL + 4, 8, 0);         // R6 before R5
    run_req(2, 'h3F000, 8192, 0);        // R5
    run_req(2, 'h1000, 6000, 0);         // R7 bad size
    run_req(2, 'h1000, 0, 0);            // R10
    run_req(3, 0, 4, 0);                 // R1 reserved op
    // constrained random
    for (int n = 0; n < 60; n++) begin
      op = int'($urandom % 3);
      md = int'($urandom % 4);
      case (md)
        0: a = longint'($urandom % 72) * SECT;
        1: a = longint'($urandom % (TOTAL + 512));
        2: a = TOTAL - longint'($urandom % 600);
        default: a = 0;
      endcase
      md = int'($urandom % 7);
      case (md)
        0: s = 0;
        1: s = longint'($urandom % 300) + 1;
        2: s = 4096;
        3: s = longint'($urandom % 6 + 1) * SECT;
        4: s = 32768;
        5: s = TOTAL;
        default: s = longint'($urandom % 20000);
      endcase
      run_req(op, a, s, int'($urandom % 3));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule